// File: doc/BRIEF.md
# Self-Test Framing Pattern Source

This block produces a continuous stream of test bytes, one per clock, for use when a high-speed serializer path is looped back on itself for self-test. Each frame it emits has the size of one OC-12 frame, 9720 bytes. The frame opens with two runs of framing bytes, twelve of the first kind and then twelve of the second kind. A payload taken from a seven-stage pseudo-random bit sequence fills the rest of the frame. A receiver downstream can lock onto the framing bytes and compare the payload against its own copy of the same sequence.

The generator runs only while the active-low test enable is held low. A low level on the frame reset input returns the generator to the start of a frame and reloads the pseudo-random source with its seed. All outputs are registered. The byte for a given clock edge appears just after that edge.

Top module: `tgen_top`

## Requirements
- R1: When `frame_rst_n` is low at a rising clock edge, the outputs just after that edge are `tx_byte` = 0x00, `tx_valid` = 0 and `tx_sof` = 0. The frame position returns to byte 0 and the pseudo-random state is reloaded with all ones.
- R2: When `test_n` is high at a rising clock edge, the outputs just after that edge are `tx_byte` = 0x00 and `tx_valid` = 0. The frame position and the pseudo-random state return to their start values, just as for R1.
- R3: The first rising edge where `frame_rst_n` is high and `test_n` is low produces byte 0 of a frame. `tx_sof` is high for that byte only and low for every other byte.
- R4: Bytes 0 to 11 of every frame are 0xF6.
- R5: Bytes 12 to 23 of every frame are 0x28.
- R6: Bytes 24 to 9719 are payload from the generator x^7 + x^6 + 1. The state s[6:0] starts at 7'h7F. Each new bit is s[6]^s[5] and is shifted in at s[0]. Eight new bits make one byte, and the first of them is the byte's MSB. The sequence advances only on payload bytes.
- R7: A frame is exactly 9720 bytes long. While enabled, `tx_sof` rises every 9720 clocks.
- R8: The pseudo-random state is not reloaded at a frame boundary. The payload of one frame carries on where the previous frame's payload stopped.
- R9: While enabled and out of reset, `tx_valid` is high on every clock, giving one byte per clock with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| frame_rst_n | input | 1 | Frame reset, active low, sampled on the clock |
| test_n | input | 1 | Test enable, active low; high means idle |
| tx_byte | output | 8 | Generated byte, zero when idle |
| tx_valid | output | 1 | High when `tx_byte` carries a frame byte |
| tx_sof | output | 1 | High on byte 0 of each frame |

## Verification
Every result is due just after the rising edge that samples its cause, because only one register stage lies between the inputs and the outputs. The reset and idle outputs appear at the edge where the control input is first sampled at its active level. Byte 0 of a frame appears at the first edge after release, and byte n appears n edges later. The bench changes inputs on falling edges and samples one nanosecond after each rising edge. It keeps its own byte index and its own model of the sequence in step with those edges, so each comparison matches the byte the design should present in that cycle.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned LFSR_W    = 7;
    localparam logic [BYTE_W-1:0] HDR1_BYTE = 8'hF6;
    localparam logic [BYTE_W-1:0] HDR2_BYTE = 8'h28;
    localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

    typedef enum logic [1:0] {
        SEG_HDR1 = 2'd0,
        SEG_HDR2 = 2'd1,
        SEG_PAY  = 2'd2
    } seg_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              valid;
        logic              sof;
    } beat_t;

    typedef struct packed {
        logic [BYTE_W-1:0] bits;
        logic [LFSR_W-1:0] next;
    } prbs_step_t;

    // Eight steps of x^7 + x^6 + 1; the first new bit lands in the MSB.
    function automatic prbs_step_t prbs_byte(input logic [LFSR_W-1:0] st);
        prbs_step_t r;
        logic [LFSR_W-1:0] s;
        logic nb;
        s = st;
        r.bits = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            nb = s[6] ^ s[5];
            r.bits = {r.bits[BYTE_W-2:0], nb};
            s = {s[LFSR_W-2:0], nb};
        end
        r.next = s;
        return r;
    endfunction

endpackage

// File: rtl/tgen_frame_ctr.sv
module tgen_frame_ctr #(
    parameter int unsigned FRAME_LEN = 9720,
    localparam int unsigned CW = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          adv,
    output logic [CW-1:0] pos
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    always_ff @(posedge clk) begin
        if (clr)
            pos <= '0;
        else if (adv)
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end
endmodule

// File: rtl/tgen_seg_decode.sv
module tgen_seg_decode
    import tgen_pkg::*;
#(
    parameter int unsigned HDR1_LEN = 12,
    parameter int unsigned HDR2_LEN = 12,
    parameter int unsigned CW = 14
) (
    input  logic [CW-1:0] pos,
    output seg_e          seg
);
    localparam logic [CW-1:0] HDR2_START = CW'(HDR1_LEN);
    localparam logic [CW-1:0] PAY_START  = CW'(HDR1_LEN + HDR2_LEN);

    always_comb begin
        if (pos < HDR2_START)
            seg = SEG_HDR1;
        else if (pos < PAY_START)
            seg = SEG_HDR2;
        else
            seg = SEG_PAY;
    end
endmodule

// File: rtl/tgen_prbs_src.sv
module tgen_prbs_src
    import tgen_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              adv,
    output logic [BYTE_W-1:0] pbyte
);
    logic [LFSR_W-1:0] state;
    prbs_step_t        step;

    always_comb step = prbs_byte(state);
    assign pbyte = step.bits;

    always_ff @(posedge clk) begin
        if (clr)
            state <= LFSR_SEED;
        else if (adv)
            state <= step.next;
    end
endmodule

// File: rtl/tgen_top.sv
module tgen_top
    import tgen_pkg::*;
#(
    parameter int unsigned HDR1_LEN = 12,
    parameter int unsigned HDR2_LEN = 12,
    parameter int unsigned PAY_LEN  = 9696
) (
    input  logic       clk,
    input  logic       frame_rst_n,
    input  logic       test_n,
    output logic [7:0] tx_byte,
    output logic       tx_valid,
    output logic       tx_sof
);
    localparam int unsigned FRAME_LEN = HDR1_LEN + HDR2_LEN + PAY_LEN;
    localparam int unsigned CW = $clog2(FRAME_LEN);

    logic          idle;
    logic [CW-1:0] pos;
    seg_e          seg;
    logic [7:0]    pbyte;
    beat_t         nxt, out_q;

    assign idle = !frame_rst_n || test_n;

    tgen_frame_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
        .clk(clk), .clr(idle), .adv(1'b1), .pos(pos)
    );

    tgen_seg_decode #(.HDR1_LEN(HDR1_LEN), .HDR2_LEN(HDR2_LEN), .CW(CW)) u_dec (
        .pos(pos), .seg(seg)
    );

    tgen_prbs_src u_prbs (
        .clk(clk), .clr(idle), .adv(seg == SEG_PAY), .pbyte(pbyte)
    );

    always_comb begin
        nxt.valid = 1'b1;
        nxt.sof   = (pos == '0);
        unique case (seg)
            SEG_HDR1: nxt.data = HDR1_BYTE;
            SEG_HDR2: nxt.data = HDR2_BYTE;
            default:  nxt.data = pbyte;
        endcase
    end

    always_ff @(posedge clk) begin
        if (idle)
            out_q <= '0;
        else
            out_q <= nxt;
    end

    assign tx_byte  = out_q.data;
    assign tx_valid = out_q.valid;
    assign tx_sof   = out_q.sof;
endmodule

// File: rtl/tgen_chk.sv
module tgen_chk #(
    parameter int unsigned HDR1_LEN = 12,
    parameter int unsigned HDR2_LEN = 12,
    parameter int unsigned PAY_LEN  = 9696
) (
    input logic       clk,
    input logic       frame_rst_n,
    input logic       test_n,
    input logic [7:0] tx_byte,
    input logic       tx_valid,
    input logic       tx_sof
);
    localparam int unsigned FRAME_LEN = HDR1_LEN + HDR2_LEN + PAY_LEN;
    localparam int unsigned CW = $clog2(FRAME_LEN) + 1;

    logic          seen;
    logic [CW-1:0] nidx;
    logic [CW-1:0] cur;

    assign cur = tx_sof ? '0 : nidx;

    always_ff @(posedge clk) begin
        if (!frame_rst_n || test_n) begin
            seen <= 1'b0;
            nidx <= '0;
        end else if (tx_valid) begin
            if (tx_sof) seen <= 1'b1;
            nidx <= cur + 1'b1;
        end
    end

    // R1
    rst_clears_chk: assert property (@(posedge clk) !frame_rst_n |=> (!tx_valid && !tx_sof && tx_byte == 8'h00));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!frame_rst_n) test_n |=> (!tx_valid && tx_byte == 8'h00));

    // R3
    sof_first_chk: assert property (@(posedge clk) disable iff (!frame_rst_n)
        (!tx_valid && !test_n) |=> tx_sof);

    // R4
    hdr1_chk: assert property (@(posedge clk) disable iff (!frame_rst_n)
        (tx_valid && seen && cur < CW'(HDR1_LEN)) |-> tx_byte == 8'hF6);

    // R5
    hdr2_chk: assert property (@(posedge clk) disable iff (!frame_rst_n)
        (tx_valid && seen && cur >= CW'(HDR1_LEN) && cur < CW'(HDR1_LEN + HDR2_LEN)) |-> tx_byte == 8'h28);

    // R7
    frame_len_chk: assert property (@(posedge clk) disable iff (!frame_rst_n)
        (tx_valid && seen) |-> (cur < CW'(FRAME_LEN)));

    // R9
    no_gap_chk: assert property (@(posedge clk) disable iff (!frame_rst_n || test_n)
        tx_valid |=> tx_valid);
endmodule

bind tgen_top tgen_chk #(.HDR1_LEN(HDR1_LEN), .HDR2_LEN(HDR2_LEN), .PAY_LEN(PAY_LEN)) u_chk (
    .clk(clk), .frame_rst_n(frame_rst_n), .test_n(test_n),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_sof(tx_sof)
);

// File: tb/tb_tgen_top.sv
module tb_tgen_top;
    localparam int FLEN = 9720;

    logic       clk = 1'b0;
    logic       frame_rst_n = 1'b0;
    logic       test_n = 1'b1;
    logic [7:0] tx_byte;
    logic       tx_valid;
    logic       tx_sof;

    int tests = 0;
    int fails = 0;
    logic [6:0] mref;

    always #4 clk = ~clk;

    tgen_top dut (
        .clk(clk), .frame_rst_n(frame_rst_n), .test_n(test_n),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_sof(tx_sof)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_byte(inout logic [6:0] s);
        logic [7:0] b;
        b = '0;
        for (int k = 7; k >= 0; k--) begin
            b[k] = s[6] ^ s[5];
            s = {s[5:0], b[k]};
        end
        return b;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Check nbytes of a frame starting at byte 0; enables are already set.
    task automatic run_frame(input int nbytes);
        int e1 = 0, e2 = 0, ep = 0, es = 0, ev = 0;
        logic [31:0] a1v = 0, a2v = 0, apv = 0, xpv = 0;
        logic [7:0] exp;
        for (int i = 0; i < nbytes; i++) begin
            tick();
            if (i < 12) exp = 8'hF6;
            else if (i < 24) exp = 8'h28;
            else exp = ref_byte(mref);
            if (tx_valid !== 1'b1) ev++;
            if (tx_sof !== (i == 0)) es++;
            if (tx_byte !== exp) begin
                if (i < 12) begin e1++; a1v = tx_byte; end
                else if (i < 24) begin e2++; a2v = tx_byte; end
                else begin if (ep == 0) begin apv = tx_byte; xpv = exp; end ep++; end
            end
        end
        chk("R4 header1 bytes", e1 == 0 ? 32'hF6 : a1v, 32'hF6);
        chk("R5 header2 bytes", e2 == 0 ? 32'h28 : a2v, 32'h28);
        chk("R6/R8 payload bytes", apv, xpv);
        chk("R3/R7 sof placement errors", es, 0);
        chk("R9 valid gaps", ev, 0);
    endtask

    task automatic t_reset_state();
        frame_rst_n = 1'b0;
        test_n = 1'b0;
        repeat (3) tick();
        chk("R1 valid in reset", tx_valid, 0);
        chk("R1 byte in reset", tx_byte, 0);
        chk("R1 sof in reset", tx_sof, 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        frame_rst_n = 1'b1;
        test_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            chk("R2 idle valid", tx_valid, 0);
            chk("R2 idle byte", tx_byte, 0);
        end
    endtask

    task automatic t_three_frames();
        @(negedge clk);
        test_n = 1'b0;
        mref = 7'h7F;
        for (int f = 0; f < 3; f++) run_frame(FLEN);
        tick();
        chk("R7 sof after three frames", tx_sof, 1);
        chk("R4 first byte of fourth frame", tx_byte, 32'hF6);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        frame_rst_n = 1'b0;
        tick();
        chk("R1 valid after mid-frame reset", tx_valid, 0);
        chk("R1 byte after mid-frame reset", tx_byte, 0);
        @(negedge clk);
        frame_rst_n = 1'b1;
        mref = 7'h7F;
        run_frame(300);
    endtask

    task automatic t_mid_idle();
        @(negedge clk);
        test_n = 1'b1;
        tick();
        chk("R2 valid after enable drop", tx_valid, 0);
        chk("R2 sof after enable drop", tx_sof, 0);
        @(negedge clk);
        test_n = 1'b0;
        mref = 7'h7F;
        run_frame(FLEN);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_idle();
        t_three_frames();
        t_mid_reset();
        t_mid_idle();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule